// File: doc/BRIEF.md
# Signed-Digit Recoder

This block turns an unsigned binary word into a signed-digit form whose digits are each -1, 0 or +1. Such a form cuts down the nonzero digits of a constant, so a constant multiplier built from it needs fewer partial products. A -1 digit means the multiplier adds the complemented multiplicand plus one. The recoder works serially. After it accepts a start strobe, it writes one digit per clock, from the least significant position upward. A single carry flag is the only state it keeps between positions.

There are two recoding modes. The canonic mode yields the nonadjacent form. In that form no two neighbouring digits are nonzero, and the nonzero count is as low as possible. The economy mode looks at each block of ones that starts at the current position. A block runs upward until two zeros in a row, and any zero inside it is isolated. The block is rewritten as a leading +1 above the block, a -1 at its base, and a -1 at each isolated zero. This happens only when the rewrite gives strictly fewer nonzero digits than the plain binary bits. Otherwise the digit stays a plain +1, and the test repeats at the next position. The result keeps negative digits few. In particular, a lone pair of ones stays in binary form.

The output has one digit more than the input, because a rewrite can carry a +1 above the top input bit.

Top module: `sd_recoder`

## Requirements
- R1: When `start` is high and `busy` is low at a clock edge, the block latches `din` and `mode`, clears both digit vectors and raises `busy` on that edge.
- R2: `done` is high for exactly one cycle. It rises at the W+1-th edge after the accepting edge, and `busy` falls at that same edge.
- R3: `start` has no effect while `busy` is high: the result belongs to the word accepted first.
- R4: Digit i has weight 2^i. `dmag[i]`=1 marks a nonzero digit. `dsgn[i]`=1 marks it as -1 and is only ever set together with `dmag[i]`.
- R5: In both modes, the sum over i of digit(i)·2^i equals the accepted input word.
- R6: In canonic mode (`mode`=0), no two adjacent digits are both nonzero.
- R7: In canonic mode, the digits equal the nonadjacent form. With a = input and t = 3a, the +1 digits are ((a^t)&t)>>1 and the -1 digits are ((a^t)&a)>>1.
- R8: In economy mode (`mode`=1), consider a position holding a 1 with no pending carry. Let k be the number of ones and z the number of isolated zeros in the block starting there. The block is rewritten only if z+2 < k. Otherwise that position emits +1 and the next position is judged again.
- R9: In economy mode, a lone pair of ones stays binary. For example, input 3 gives +1 digits at positions 0 and 1 and no -1 digit.
- R10: In economy mode, the count of nonzero digits never exceeds the count of ones in the input.
- R11: After reset, `busy`, `done`, `dmag` and `dsgn` are all zero.
- R12: After `done`, the digit vectors hold their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin recoding `din` when idle |
| mode | input | 1 | 0 canonic, 1 economy |
| din | input | W | Unsigned word to recode |
| busy | output | 1 | Recoding in progress |
| done | output | 1 | One-cycle pulse when digits are complete |
| dmag | output | W+1 | Nonzero flag per digit |
| dsgn | output | W+1 | Negative flag per digit |

## Verification
The only timed result is the completion. It is due W+1 edges after the edge that accepts `start`, and the digit vectors become valid on that same edge. When the driver issues a job, it stamps the expected completion cycle from a free-running cycle counter. The monitor samples on falling edges, so it reads `done` and the digits half a cycle after they change, and it compares the counter against the stamp. The bench checks every input word of the default width in both modes against independently computed digit patterns.

// File: rtl/sd_recoder.sv
module sd_recoder #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         mode,
  input  logic [W-1:0] din,
  output logic         busy,
  output logic         done,
  output logic [W:0]   dmag,
  output logic [W:0]   dsgn
);
  localparam int CW = $clog2(W + 2);

  logic [W+1:0]  word_q;
  logic          mode_q;
  logic [CW-1:0] pos;
  logic          carry;
  logic [W+1:0]  win;

  logic [CW-1:0] ones, gaps;
  logic          live, rewrite;
  logic          nz, neg, carry_nx;

  assign win = word_q >> pos;

  always_comb begin
    ones = '0;
    gaps = '0;
    live = 1'b1;
    for (int j = 0; j <= W; j++) begin
      if (live) begin
        if (win[j])        ones = ones + 1'b1;
        else if (win[j+1]) gaps = gaps + 1'b1;
        else               live = 1'b0;
      end
    end
  end

  assign rewrite = mode_q ? (int'(gaps) + 2 < int'(ones)) : win[1];

  always_comb begin
    nz = 1'b0;
    neg = 1'b0;
    carry_nx = 1'b0;
    unique case ({carry, win[0]})
      2'b00: ;
      2'b01: begin nz = 1'b1; neg = rewrite; carry_nx = rewrite; end
      2'b11: carry_nx = 1'b1;
      2'b10: begin nz = 1'b1; neg = win[1]; carry_nx = win[1]; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      mode_q <= 1'b0;
      pos    <= '0;
      carry  <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      dmag   <= '0;
      dsgn   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        word_q <= {2'b00, din};
        mode_q <= mode;
        pos    <= '0;
        carry  <= 1'b0;
        dmag   <= '0;
        dsgn   <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        dmag[pos] <= nz;
        dsgn[pos] <= neg;
        carry     <= carry_nx;
        pos       <= pos + 1'b1;
        if (pos == CW'(W)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sd_recoder_chk.sv
module sd_recoder_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] din,
  input logic         busy,
  input logic         done,
  input logic         mode_q,
  input logic         carry,
  input logic [W+1:0] word_q,
  input logic [W:0]   dmag,
  input logic [W:0]   dsgn
);
  function automatic longint digit_sum(logic [W:0] m, logic [W:0] s);
    longint acc = 0;
    for (int i = 0; i <= W; i++)
      if (m[i]) acc = s[i] ? acc - (longint'(1) << i) : acc + (longint'(1) << i);
    return acc;
  endfunction

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && (word_q[W-1:0] == $past(din)));

  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(word_q) && $stable(mode_q));

  p_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dsgn & ~dmag) == '0);

  p_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> digit_sum(dmag, dsgn) == longint'(word_q));

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !carry);

  p_adjacent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_q |-> (dmag & (dmag >> 1)) == '0);

  p_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done && mode_q |-> $countones(dmag) <= $countones(word_q));
endmodule

bind sd_recoder sd_recoder_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .din(din), .busy(busy),
  .done(done), .mode_q(mode_q), .carry(carry), .word_q(word_q),
  .dmag(dmag), .dsgn(dsgn)
);

// File: tb/sim_sd_recoder.sv
`timescale 1ns/1ps
module sim_sd_recoder;
  localparam int W = 8;

  typedef struct packed {
    logic [W:0]   m;
    logic [W:0]   s;
    logic [W-1:0] x;
    logic         md;
    logic [31:0]  due;
  } job_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode = 1'b0;
  logic [W-1:0] din = '0;
  logic busy, done;
  logic [W:0] dmag, dsgn;
  logic [31:0] cyc = 0;
  int checks = 0, errors = 0;
  job_t exp_q[$];

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 1;

  sd_recoder #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .din(din),
    .busy(busy), .done(done), .dmag(dmag), .dsgn(dsgn)
  );

  function automatic logic [2*W+1:0] naf_ref(logic [W-1:0] x);
    logic [W+1:0] a, t, d, p, n;
    a = {2'b00, x};
    t = a + (a << 1);
    d = a ^ t;
    p = (d & t) >> 1;
    n = (d & a) >> 1;
    return {p[W:0] | n[W:0], n[W:0]};
  endfunction

  function automatic logic [2*W+1:0] eco_ref(logic [W-1:0] x);
    logic [W+2:0] b;
    logic [W:0] m, s;
    int i, e, k, z;
    b = {3'b000, x};
    m = {1'b0, x};
    s = '0;
    i = 0;
    while (i < W) begin
      if (b[i]) begin
        e = i; k = 0; z = 0;
        while (b[e] || b[e+1]) begin
          if (b[e]) k++; else z++;
          e++;
        end
        if (z + 2 < k) begin
          for (int j = i; j < e; j++) begin
            if (j == i || !b[j]) begin m[j] = 1'b1; s[j] = 1'b1; end
            else m[j] = 1'b0;
          end
          m[e] = 1'b1; s[e] = 1'b0;
          i = e + 1;
        end else i++;
      end else i++;
    end
    return {m, s};
  endfunction

  function automatic longint dsum(logic [W:0] m, logic [W:0] s);
    longint acc = 0;
    for (int i = 0; i <= W; i++)
      if (m[i]) acc = s[i] ? acc - (longint'(1) << i) : acc + (longint'(1) << i);
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, expv, cyc);
    end
  endtask

  task automatic issue(input logic [W-1:0] x, input logic md);
    job_t j;
    logic [2*W+1:0] r;
    @(negedge clk);
    r = md ? eco_ref(x) : naf_ref(x);
    j.m = r[2*W+1:W+1];
    j.s = r[W:0];
    j.x = x;
    j.md = md;
    j.due = cyc + W + 2;
    exp_q.push_back(j);
    din = x; mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin : monitor
    job_t j;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected done", 1, 0);
        end else begin
          j = exp_q.pop_front();
          check(cyc == j.due, "R2 done timing", cyc, j.due);
          check(busy == 1'b0, "R2 busy low at done", busy, 0);
          check(dmag == j.m, j.md ? "R8 economy magnitudes" : "R7 canonic magnitudes", dmag, j.m);
          check(dsgn == j.s, j.md ? "R8 economy signs" : "R7 canonic signs", dsgn, j.s);
          check((dsgn & ~dmag) == '0, "R4 sign without magnitude", dsgn, dmag);
          check(dsum(dmag, dsgn) == longint'(j.x), "R5 digit sum", dsum(dmag, dsgn), j.x);
          if (!j.md)
            check((dmag & (dmag >> 1)) == '0, "R6 adjacent nonzero", dmag, 0);
          else
            check($countones(dmag) <= $countones(j.x), "R10 nonzero count", $countones(dmag), $countones(j.x));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [W:0] m_hold, s_hold;
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R11 reset flags", {busy, done}, 0);
    check(dmag == '0 && dsgn == '0, "R11 reset digits", {dmag, dsgn}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R2 exercised through each issued job
    for (int md = 0; md < 2; md++)
      for (int v = 0; v < (1 << W); v++) begin
        issue(W'(v), md[0]);
        drain();
      end

    // R9 lone pair kept binary in economy mode
    issue(W'(3), 1'b1);
    drain();
    check(dmag == (W+1)'(3) && dsgn == '0, "R9 pair kept binary", {dmag, dsgn}, (W+1)'(3) << (W+1));
    issue(W'(3), 1'b0);
    drain();
    check(dmag == (W+1)'(5) && dsgn == (W+1)'(1), "R9 canonic pair rewritten", {dmag, dsgn}, {(W+1)'(5), (W+1)'(1)});

    // R3 start while busy ignored
    issue(W'(8'hB7), 1'b0);
    din = W'(8'h11); mode = 1'b1; start = 1'b1;
    repeat (3) @(negedge clk);
    start = 1'b0;
    drain();

    // R12 result held after done
    m_hold = dmag; s_hold = dsgn;
    repeat (5) @(negedge clk);
    check(dmag == m_hold && dsgn == s_hold, "R12 digits held", {dmag, dsgn}, {m_hold, s_hold});
    check(done == 1'b0 && busy == 1'b0, "R2 done is one cycle", {busy, done}, 0);

    issue(W'(8'hFF), 1'b1);
    drain();
    check(dmag[W] == 1'b1 && dsgn[0] == 1'b1, "R8 all ones rewritten", {dmag, dsgn}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule